// File: doc/BRIEF.md
# Single-Byte Multi-Line SPI Flash Read Engine

This block reads a serial flash one byte at a time, under programmed I/O. Software writes the start address, chooses the line mode and the dummy policy, and leaves two opcodes ready. Each start command then runs one complete SPI read transaction and returns one byte. The address counter then moves forward, so repeating the command streams consecutive bytes. Every transaction has the same order of phases: an 8-bit opcode on a single line, a 3- or 4-byte address, an optional 8-clock dummy gap, and then one data byte received over one, two or four lines.

The engine is a five-state machine built from `ST_IDLE`, `ST_OPCODE`, `ST_ADDR`, `ST_DUMMY` and `ST_DATA`. The transitions are: IDLE→OPCODE on a valid start command; OPCODE→ADDR after 8 clocks; ADDR→DUMMY when dummy clocks are enabled, otherwise ADDR→DATA; DUMMY→DATA after 8 clocks; DATA→IDLE after the last data beat, at which point the byte is latched and the address steps. Every state other than IDLE runs the serial clock at half the system clock rate, in SPI mode 0.

Top module: `spi_byte_reader`

## Requirements
- R1: After reset `busy` is 0, `spi_cs_n` is 1, `spi_sck` is 0, `spi_io_oe` is 0 and `cur_addr` is 0.
- R2: Only a `cmd_wr` pulse with `cmd_code` equal to 0x81, given while idle, starts a read. Any other code leaves the bus untouched, leaves the address unchanged and leaves `busy` at 0.
- R3: The opcode is sent first, MSB first, on IO0 only, over 8 clocks. It is taken from `op_slot4` when `mode_reg` bit 2 is 1, and from `op_slot3` otherwise.
- R4: The address length is 3 bytes (the low 24 bits of the counter) when `mode_reg` bit 4 is 0, and 4 bytes when it is 1. It is sent MSB first.
- R5: The address uses four lines (IO3..IO0, 4 bits per clock) when `mode_reg` bit 3 is 1. Otherwise it uses two lines (IO1:IO0) when bit 1 is 1, and one line (IO0) when both are 0. On each clock the higher-numbered line carries the more significant bit.
- R6: Exactly 8 dummy clocks follow the address when `fast_rd` is 1 or any of `mode_reg` bits 3..0 is 1. Otherwise there are none. `spi_io_oe` is 0 in the dummy and data phases.
- R7: Data is received MSB first. It uses four lines (IO3..IO0) when `mode_reg` bit 2 is 1, otherwise two lines (IO1:IO0) when bit 0 is 1, otherwise one line (IO1). The data phase therefore takes 2, 4 or 8 clocks.
- R8: When a read completes, `busy` falls, `rd_data` holds the received byte and `cur_addr` has advanced by one. Repeated starts return consecutive bytes.
- R9: `addr_wr` loads `cur_addr` from `addr_wdata` while idle and is ignored while busy.
- R10: `spi_cs_n` stays low for the whole transaction. `spi_sck` idles low and toggles every system clock while a transaction runs. Outputs change while `spi_sck` is low, and `spi_io_in` is sampled on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_reg | input | 8 | Line-mode and address-length selection |
| fast_rd | input | 1 | Insert dummy clocks in single-line mode |
| op_slot3 | input | 8 | Opcode for single and dual reads |
| op_slot4 | input | 8 | Opcode for quad reads |
| addr_wr | input | 1 | Load the address counter |
| addr_wdata | input | 32 | Value to load into the address counter |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0x81 starts a byte read) |
| busy | output | 1 | Transaction in progress |
| rd_data | output | 8 | Last byte read |
| cur_addr | output | 32 | Address of the next byte to read |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_out | output | 4 | Values driven on IO3..IO0 |
| spi_io_oe | output | 4 | Output enables for IO3..IO0 |
| spi_io_in | input | 4 | Values sampled from IO3..IO0 |

## Verification
`busy` rises on the edge that takes in the start command. Each serial clock then takes two system cycles. A transaction therefore lasts twice the sum of 8, the address beats, the dummy clocks and the data beats. `rd_data`, `cur_addr` and the fall of `busy` all update together on the final edge. The bench drives on the falling system edge and polls `busy` there. It reads the results half a period after they change, and never needs a fixed cycle count. The flash model in the bench counts rising serial edges to check the clock total exactly. It also captures the opcode and the address, and it drives each data group on the serial falling edge that comes before the rising edge where it is sampled.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA
    } rd_state_e;

    typedef enum logic [1:0] {
        LN_X1 = 2'd0,
        LN_X2 = 2'd1,
        LN_X4 = 2'd2
    } lanes_e;

    // log2 of the number of lines in use
    function automatic int unsigned lane_shift(lanes_e l);
        unique case (l)
            LN_X2:   return 1;
            LN_X4:   return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sfr_mode_decode.sv
module sfr_mode_decode
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DUMMY_CLKS = 8,
    localparam int CW = $clog2(ADDR_W + 1)
) (
    input  logic [7:0]    mode_reg,
    input  logic          fast_rd,
    input  logic [7:0]    op_slot3,
    input  logic [7:0]    op_slot4,
    output lanes_e        addr_ln,
    output lanes_e        data_ln,
    output logic          wide_addr,
    output logic          use_dummy,
    output logic [7:0]    opcode,
    output logic [CW-1:0] addr_last,
    output logic [CW-1:0] data_last,
    output logic [CW-1:0] dummy_last
);
    localparam int NARROW_W = ADDR_W - 8;

    always_comb begin
        if (mode_reg[3])      addr_ln = LN_X4;
        else if (mode_reg[1]) addr_ln = LN_X2;
        else                  addr_ln = LN_X1;

        if (mode_reg[2])      data_ln = LN_X4;
        else if (mode_reg[0]) data_ln = LN_X2;
        else                  data_ln = LN_X1;

        wide_addr  = mode_reg[4];
        use_dummy  = fast_rd | (|mode_reg[3:0]);
        opcode     = mode_reg[2] ? op_slot4 : op_slot3;
        addr_last  = CW'((wide_addr ? ADDR_W : NARROW_W) >> lane_shift(addr_ln)) - CW'(1);
        data_last  = CW'(8 >> lane_shift(data_ln)) - CW'(1);
        dummy_last = CW'(DUMMY_CLKS - 1);
    end

endmodule

// File: rtl/sfr_lane_shifter.sv
module sfr_lane_shifter
    import sfr_pkg::*;
#(
    parameter int SR_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SR_W-1:0] load_val,
    input  logic            tx_shift,
    input  lanes_e          tx_ln,
    input  logic            rx_shift,
    input  lanes_e          rx_ln,
    input  logic [3:0]      io_in,
    output logic [3:0]      tx_bits,
    output logic [7:0]      rx_byte
);
    logic [SR_W-1:0] tx_q;
    logic [7:0]      rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load) begin
                tx_q <= load_val;
                rx_q <= '0;
            end else begin
                if (tx_shift) begin
                    unique case (tx_ln)
                        LN_X2:   tx_q <= {tx_q[SR_W-3:0], 2'b00};
                        LN_X4:   tx_q <= {tx_q[SR_W-5:0], 4'b0000};
                        default: tx_q <= {tx_q[SR_W-2:0], 1'b0};
                    endcase
                end
                if (rx_shift) begin
                    unique case (rx_ln)
                        LN_X2:   rx_q <= {rx_q[5:0], io_in[1:0]};
                        LN_X4:   rx_q <= {rx_q[3:0], io_in};
                        default: rx_q <= {rx_q[6:0], io_in[1]};
                    endcase
                end
            end
        end
    end

    always_comb begin
        unique case (tx_ln)
            LN_X2:   tx_bits = {2'b00, tx_q[SR_W-1 -: 2]};
            LN_X4:   tx_bits = tx_q[SR_W-1 -: 4];
            default: tx_bits = {3'b000, tx_q[SR_W-1]};
        endcase
    end

    assign rx_byte = rx_q;

endmodule

// File: rtl/spi_byte_reader.sv
module spi_byte_reader
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DUMMY_CLKS = 8,
    parameter logic [7:0] START_CODE = 8'h81
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        mode_reg,
    input  logic              fast_rd,
    input  logic [7:0]        op_slot3,
    input  logic [7:0]        op_slot4,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_code,
    output logic              busy,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic [3:0]        spi_io_out,
    output logic [3:0]        spi_io_oe,
    input  logic [3:0]        spi_io_in
);
    localparam int CW = $clog2(ADDR_W + 1);

    // decoded configuration (live inputs and snapshot)
    lanes_e          dec_addr_ln, dec_data_ln;
    logic            dec_wide, dec_dummy;
    logic [7:0]      dec_opcode;
    logic [CW-1:0]   dec_addr_last, dec_data_last, dec_dummy_last;

    lanes_e          cfg_addr_ln, cfg_data_ln;
    logic            cfg_wide, cfg_dummy;
    logic [CW-1:0]   cfg_addr_last, cfg_data_last, cfg_dummy_last;

    rd_state_e       state_q, state_d;
    logic            ph_q;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]      data_q;

    logic            start, beat_end, last_beat;
    logic            sh_load, sh_tx, sh_rx;
    logic [ADDR_W-1:0] sh_val;
    lanes_e          tx_ln;
    logic [3:0]      tx_bits;
    logic [7:0]      rx_byte;

    sfr_mode_decode #(.ADDR_W(ADDR_W), .DUMMY_CLKS(DUMMY_CLKS)) u_dec (
        .mode_reg   (mode_reg),
        .fast_rd    (fast_rd),
        .op_slot3   (op_slot3),
        .op_slot4   (op_slot4),
        .addr_ln    (dec_addr_ln),
        .data_ln    (dec_data_ln),
        .wide_addr  (dec_wide),
        .use_dummy  (dec_dummy),
        .opcode     (dec_opcode),
        .addr_last  (dec_addr_last),
        .data_last  (dec_data_last),
        .dummy_last (dec_dummy_last)
    );

    assign start     = (state_q == ST_IDLE) && cmd_wr && (cmd_code == START_CODE);
    assign beat_end  = (state_q != ST_IDLE) && ph_q;   // sck high -> falling next
    assign last_beat = beat_end && (cnt_q == '0);

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_OPCODE;
                    cnt_d   = CW'(7);
                end
            end
            ST_OPCODE: begin
                if (last_beat) begin
                    state_d = ST_ADDR;
                    cnt_d   = cfg_addr_last;
                end else if (beat_end) cnt_d = cnt_q - CW'(1);
            end
            ST_ADDR: begin
                if (last_beat) begin
                    state_d = cfg_dummy ? ST_DUMMY : ST_DATA;
                    cnt_d   = cfg_dummy ? cfg_dummy_last : cfg_data_last;
                end else if (beat_end) cnt_d = cnt_q - CW'(1);
            end
            ST_DUMMY: begin
                if (last_beat) begin
                    state_d = ST_DATA;
                    cnt_d   = cfg_data_last;
                end else if (beat_end) cnt_d = cnt_q - CW'(1);
            end
            ST_DATA: begin
                if (last_beat) state_d = ST_IDLE;
                else if (beat_end) cnt_d = cnt_q - CW'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            ph_q           <= 1'b0;
            cnt_q          <= '0;
            addr_q         <= '0;
            data_q         <= '0;
            cfg_addr_ln    <= LN_X1;
            cfg_data_ln    <= LN_X1;
            cfg_wide       <= 1'b0;
            cfg_dummy      <= 1'b0;
            cfg_addr_last  <= '0;
            cfg_data_last  <= '0;
            cfg_dummy_last <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ph_q    <= (state_q == ST_IDLE) ? 1'b0 : ~ph_q;
            if (start) begin
                cfg_addr_ln    <= dec_addr_ln;
                cfg_data_ln    <= dec_data_ln;
                cfg_wide       <= dec_wide;
                cfg_dummy      <= dec_dummy;
                cfg_addr_last  <= dec_addr_last;
                cfg_data_last  <= dec_data_last;
                cfg_dummy_last <= dec_dummy_last;
            end
            if ((state_q == ST_IDLE) && addr_wr) addr_q <= addr_wdata;
            if ((state_q == ST_DATA) && last_beat) begin
                data_q <= rx_byte;
                addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    // shifter control
    assign sh_load = start || ((state_q == ST_OPCODE) && last_beat);
    assign sh_val  = start ? {dec_opcode, {(ADDR_W-8){1'b0}}}
                           : (cfg_wide ? addr_q : {addr_q[ADDR_W-9:0], 8'h00});
    assign sh_tx   = beat_end && ((state_q == ST_OPCODE) || (state_q == ST_ADDR));
    assign sh_rx   = (state_q == ST_DATA) && !ph_q;
    assign tx_ln   = (state_q == ST_ADDR) ? cfg_addr_ln : LN_X1;

    sfr_lane_shifter #(.SR_W(ADDR_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .tx_shift (sh_tx),
        .tx_ln    (tx_ln),
        .rx_shift (sh_rx),
        .rx_ln    (cfg_data_ln),
        .io_in    (spi_io_in),
        .tx_bits  (tx_bits),
        .rx_byte  (rx_byte)
    );

    // output process
    always_comb begin
        busy       = (state_q != ST_IDLE);
        spi_cs_n   = (state_q == ST_IDLE);
        spi_sck    = ph_q && (state_q != ST_IDLE);
        spi_io_out = 4'b0000;
        spi_io_oe  = 4'b0000;
        unique case (state_q)
            ST_OPCODE: begin
                spi_io_out = tx_bits;
                spi_io_oe  = 4'b0001;
            end
            ST_ADDR: begin
                spi_io_out = tx_bits;
                unique case (cfg_addr_ln)
                    LN_X2:   spi_io_oe = 4'b0011;
                    LN_X4:   spi_io_oe = 4'b1111;
                    default: spi_io_oe = 4'b0001;
                endcase
            end
            default: ;
        endcase
        rd_data  = data_q;
        cur_addr = addr_q;
    end

    // ---------------- assertions ----------------
    assert_ignore_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_wr && cmd_code == START_CODE)) |=> !busy);

    assert_lane_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(spi_io_oe) != 3));

    assert_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DUMMY) || (state_q == ST_DATA)) |-> (spi_io_oe == 4'b0000));

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(rd_data));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_addr));

    assert_sck_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (spi_sck != $past(spi_sck)));

    assert_cs_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_sck && spi_io_oe == 4'b0000));

endmodule

// File: tb/sim_spi_byte_reader.sv
module sim_spi_byte_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mode_reg = '0;
    logic        fast_rd = 1'b0;
    logic [7:0]  op_slot3 = 8'h0B;
    logic [7:0]  op_slot4 = 8'h6B;
    logic        addr_wr = 1'b0;
    logic [31:0] addr_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        busy;
    logic [7:0]  rd_data;
    logic [31:0] cur_addr;
    logic        spi_sck, spi_cs_n;
    logic [3:0]  spi_io_out, spi_io_oe;
    logic [3:0]  spi_io_in = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    spi_byte_reader u0 (
        .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .fast_rd(fast_rd),
        .op_slot3(op_slot3), .op_slot4(op_slot4), .addr_wr(addr_wr),
        .addr_wdata(addr_wdata), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .busy(busy), .rd_data(rd_data), .cur_addr(cur_addr),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
        .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
    );

    // ---------------- flash model ----------------
    int          m_aw = 1, m_dw = 1, m_na = 24, m_nd = 0;
    int          rises = 0;
    logic [7:0]  op_cap = '0;
    logic [31:0] addr_cap = '0;

    function automatic logic [7:0] fl_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hA5;
    endfunction

    always @(negedge spi_cs_n) begin
        rises    = 0;
        op_cap   = '0;
        addr_cap = '0;
    end

    always @(posedge spi_sck) begin
        if (rises < 8) op_cap = {op_cap[6:0], spi_io_out[0]};
        else if (rises < 8 + m_na) begin
            if (m_aw == 4)      addr_cap = {addr_cap[27:0], spi_io_out};
            else if (m_aw == 2) addr_cap = {addr_cap[29:0], spi_io_out[1:0]};
            else                addr_cap = {addr_cap[30:0], spi_io_out[0]};
        end
        rises = rises + 1;
    end

    always @(negedge spi_sck) begin
        int j;
        logic [7:0] b;
        j = rises - (8 + m_na + m_nd);
        b = fl_byte(addr_cap);
        if (j >= 0 && j < 8 / m_dw) begin
            if (m_dw == 4)      spi_io_in = b[7 - 4*j -: 4];
            else if (m_dw == 2) spi_io_in = {2'b00, b[7 - 2*j -: 2]};
            else                spi_io_in = {2'b00, b[7 - j], 1'b0};
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic do_read(input logic [7:0] mode, input logic fast, input logic [31:0] base);
        logic [31:0] ea;
        logic [7:0]  eop;
        int          total;
        m_aw = mode[3] ? 4 : (mode[1] ? 2 : 1);
        m_dw = mode[2] ? 4 : (mode[0] ? 2 : 1);
        m_na = (mode[4] ? 32 : 24) / m_aw;
        m_nd = (fast || (|mode[3:0])) ? 8 : 0;
        ea   = mode[4] ? base : {8'h00, base[23:0]};
        eop  = mode[2] ? op_slot4 : op_slot3;
        total = 8 + m_na + m_nd + 8 / m_dw;
        @(negedge clk);
        mode_reg = mode;
        fast_rd  = fast;
        cmd_wr   = 1'b1;
        cmd_code = 8'h81;
        @(negedge clk);
        cmd_wr   = 1'b0;
        chk(busy === 1'b1, "R2 start accepted", 32'(busy), 1);
        wait_idle();
        chk(op_cap == eop, "R3 opcode", 32'(op_cap), 32'(eop));
        chk(addr_cap == ea, "R4/R5 address", addr_cap, ea);
        chk(rises == total, "R6/R7 clock count", rises, total);
        chk(rd_data == fl_byte(ea), "R7 data byte", 32'(rd_data), 32'(fl_byte(ea)));
        chk(cur_addr == base + 1, "R8 address step", cur_addr, base + 1);
        chk(busy == 1'b0 && spi_cs_n == 1'b1, "R10 bus released", {spi_cs_n, busy}, 2);
    endtask

    task automatic load_addr(input logic [31:0] a);
        @(negedge clk);
        addr_wr    = 1'b1;
        addr_wdata = a;
        @(negedge clk);
        addr_wr    = 1'b0;
        chk(cur_addr == a, "R9 idle load", cur_addr, a);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
        chk(spi_cs_n == 1'b1, "R1 cs_n", 32'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R1 sck", 32'(spi_sck), 0);
        chk(spi_io_oe == 4'h0, "R1 oe", 32'(spi_io_oe), 0);
        chk(cur_addr == 32'h0, "R1 addr", cur_addr, 0);
    endtask

    task automatic t_ignore();
        logic [31:0] a0;
        int r0;
        a0 = cur_addr;
        r0 = rises;
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_code = 8'h90;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R2 other code no busy", 32'(busy), 0);
        chk(spi_cs_n == 1'b1, "R2 other code cs_n", 32'(spi_cs_n), 1);
        chk(cur_addr == a0, "R2 other code addr", cur_addr, a0);
        chk(rises == r0, "R2 other code no sck", rises, r0);
    endtask

    task automatic t_load_busy();
        logic [31:0] base;
        base = cur_addr;
        @(negedge clk);
        mode_reg = 8'h00; fast_rd = 1'b0;
        m_aw = 1; m_dw = 1; m_na = 24; m_nd = 0;
        cmd_wr = 1'b1; cmd_code = 8'h81;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (5) @(negedge clk);
        addr_wr = 1'b1; addr_wdata = 32'hDEAD_0000;
        @(negedge clk);
        addr_wr = 1'b0;
        wait_idle();
        chk(cur_addr == base + 1, "R9 load ignored while busy", cur_addr, base + 1);
    endtask

    task automatic t_stream();
        load_addr(32'h0000_1FFE);
        for (int i = 0; i < 3; i++) do_read(8'h01, 1'b0, 32'h0000_1FFE + i); // R8 consecutive
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignore();
        load_addr(32'h0012_3456);
        do_read(8'h00, 1'b0, 32'h0012_3456);   // plain single
        do_read(8'h00, 1'b1, 32'h0012_3457);   // fast single
        load_addr(32'h00AB_CDEF);
        do_read(8'h01, 1'b0, 32'h00AB_CDEF);   // dual data
        do_read(8'h04, 1'b0, 32'h00AB_CDF0);   // quad data, slot 4
        do_read(8'h03, 1'b0, 32'h00AB_CDF1);   // dual addr + data
        do_read(8'h0C, 1'b0, 32'h00AB_CDF2);   // quad addr + data
        do_read(8'h08, 1'b0, 32'h00AB_CDF3);   // quad addr, single data
        load_addr(32'h8765_4321);
        do_read(8'h10, 1'b0, 32'h8765_4321);   // 4-byte single
        do_read(8'h1C, 1'b0, 32'h8765_4322);   // 4-byte quad
        load_addr(32'h7F00_0000);
        do_read(8'h00, 1'b0, 32'h7F00_0000);   // 3-byte drops upper byte
        t_load_busy();
        t_stream();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule